// File: doc/BRIEF.md
# SDRAM Mode Word Decoder and Column Burst Sequencer

This block sits beside an SDRAM command engine. When a mode-register-set command goes out, it captures the 14-bit mode word from the bank and address lines. It checks every field of that word and keeps only legal settings. On each read or write start it produces the column address sequence that the programmed burst implies, with one column per clock. For reads it also produces a data-valid strobe that trails each issued column by the programmed CAS latency.

The burst follows the stored settings:
- Length: 1, 2, 4 or 8 columns, or a full page.
- Order: sequential (wrapping inside the burst-aligned block) or interleaved (XOR with a running count).
- Write policy: writes follow the burst length, or a single-write policy makes every write touch only its start column while reads still burst.

A full-page burst walks all columns with wrap-around until a terminate strobe or a new start arrives. A new start always preempts the burst in progress. Mode words with a reserved code raise a flag and leave the stored settings untouched.

Top module: `sdram_burst_seq`

## Requirements
- R1: `mode_word` bit 13..8 = write opcode (BA1,BA0,A11,A10,A9,A8), bit 7 = test bit, bits 6..4 = latency code, bit 3 = order (0 sequential, 1 interleaved), bits 2..0 = length code. One cycle after `mode_set`, `mode_illegal` shows whether that word was rejected. A legal word clears the flag, and the flag holds until the next `mode_set`.
- R2: One cycle after `rd_start` or `wr_start`, `col_valid` is high and `col_addr` equals `start_col`. If both strobes are high together, the burst is a read.
- R3: Length codes 000, 001, 010 and 011 give 1, 2, 4 and 8 columns on consecutive cycles. After the last column, `col_valid` falls.
- R4: In sequential order, the low log2(length) column bits count upward from the start and wrap inside the aligned block. The upper bits stay fixed.
- R5: In interleaved order, the low log2(length) bits equal the start bits XOR a count 0,1,2,…, and the upper bits stay fixed.
- R6: Length code 111 with sequential order gives a full-page burst. It runs through all 512 columns, wraps from 511 to 0, and does not end by itself.
- R7: Opcode 000000 makes writes burst for the programmed length. Opcode 000010 (only A9 set) makes each write issue just the start column, while reads keep the programmed length.
- R8: A `burst_stop` with no start drops `col_valid` on the next cycle. A new start during a burst replaces that burst on the next cycle.
- R9: `rd_valid` repeats the read column-valid pattern delayed by 2 cycles (latency code 010) or 3 cycles (latency code 011). Write columns produce no `rd_valid`.
- R10: Each of the following raises `mode_illegal` and leaves all stored settings unchanged: test bit 1, length codes 100–110, length code 111 with interleaved order, latency codes other than 010 and 011, and opcodes other than the two in R7.
- R11: After reset, `col_valid`, `rd_valid`, `busy` and `mode_illegal` are low. The settings are sequential order, length 1, latency 2, burst writes.
- R12: `busy` is high while a column is issued or while a read column issued within the last latency cycles still owes its `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_set | input | 1 | Capture `mode_word` this cycle |
| mode_word | input | 14 | {BA1,BA0,A11..A0} during mode set |
| rd_start | input | 1 | Start a read burst |
| wr_start | input | 1 | Start a write burst |
| start_col | input | 9 | First column of the burst |
| burst_stop | input | 1 | Terminate the current burst |
| col_addr | output | 9 | Column issued this cycle |
| col_valid | output | 1 | `col_addr` is valid |
| rd_valid | output | 1 | Read data due this cycle |
| mode_illegal | output | 1 | Last mode word was rejected |
| busy | output | 1 | Burst or read data outstanding |

## Verification
The bench targets the following corner cases, and the failure each one exposes:
- Start columns that are not aligned to the burst, in both orders. A design that carries into the upper column bits, or that adds where it should XOR, issues addresses outside the aligned block.
- A full-page read started near column 511. A design that saturates, or that ends after eight columns, breaks the wrap to 0.
- Writes under the single-write opcode. A design that applies that policy to reads, or ignores it for writes, gets the column count wrong.
- Every reserved code, each followed by a read. A design that half-applies a rejected word shows a changed length or latency on that read.
- A stop, a preemption mid-burst and a read started together with a write. A design that gets these wrong shows a column too many or the wrong direction.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [2:0] {
    BL_1    = 3'd0,
    BL_2    = 3'd1,
    BL_4    = 3'd2,
    BL_8    = 3'd3,
    BL_FULL = 3'd4
  } blen_e;

  typedef struct packed {
    logic  interleave;
    logic  cas3;
    blen_e blen;
    logic  single_wr;
  } mode_t;

  localparam mode_t MODE_RESET = '{interleave: 1'b0, cas3: 1'b0,
                                   blen: BL_1, single_wr: 1'b0};

  localparam int MW_W      = 14;
  localparam int OP_LSB    = 8;
  localparam int TEST_BIT  = 7;
  localparam int CL_LSB    = 4;
  localparam int ORDER_BIT = 3;
  localparam int LEN_LSB   = 0;

  localparam logic [5:0] OP_BURST_WR  = 6'b000000;
  localparam logic [5:0] OP_SINGLE_WR = 6'b000010;

endpackage

// File: rtl/sbs_mode_reg.sv
module sbs_mode_reg
  import sbs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_set,
  input  logic [MW_W-1:0] mode_word,
  output mode_t           mode,
  output logic            illegal
);

  logic [5:0] op;
  logic [2:0] cl_code;
  logic [2:0] len_code;
  logic       order;
  logic       test_bit;

  mode_t cand;
  logic  ok_op, ok_cl, ok_len, legal;
  mode_t mode_q, mode_d;
  logic  ill_q, ill_d;

  assign op       = mode_word[OP_LSB +: 6];
  assign test_bit = mode_word[TEST_BIT];
  assign cl_code  = mode_word[CL_LSB +: 3];
  assign order    = mode_word[ORDER_BIT];
  assign len_code = mode_word[LEN_LSB +: 3];

  always_comb begin
    cand            = MODE_RESET;
    cand.interleave = order;
    cand.cas3       = (cl_code == 3'b011);
    cand.single_wr  = (op == OP_SINGLE_WR);
    ok_op           = (op == OP_BURST_WR) || (op == OP_SINGLE_WR);
    ok_cl           = (cl_code == 3'b010) || (cl_code == 3'b011);
    ok_len          = 1'b1;
    case (len_code)
      3'b000:  cand.blen = BL_1;
      3'b001:  cand.blen = BL_2;
      3'b010:  cand.blen = BL_4;
      3'b011:  cand.blen = BL_8;
      3'b111: begin
        cand.blen = BL_FULL;
        ok_len    = !order;
      end
      default: ok_len = 1'b0;
    endcase
    legal = ok_op && ok_cl && ok_len && !test_bit;
  end

  always_comb begin
    mode_d = mode_q;
    ill_d  = ill_q;
    if (mode_set) begin
      ill_d = !legal;
      if (legal) mode_d = cand;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
      ill_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ill_q  <= ill_d;
    end
  end

  assign mode    = mode_q;
  assign illegal = ill_q;

endmodule

// File: rtl/sbs_col_gen.sv
module sbs_col_gen
  import sbs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_t            mode,
  input  logic             rd_start,
  input  logic             wr_start,
  input  logic [COL_W-1:0] start_col,
  input  logic             burst_stop,
  output logic [COL_W-1:0] col_addr,
  output logic             col_valid,
  output logic             col_is_read
);

  logic             act_q, act_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [COL_W-1:0] cnt_q, cnt_d;
  logic [COL_W-1:0] mask_q, mask_d;
  logic             full_q, full_d;
  logic             ilv_q, ilv_d;
  logic             rd_q, rd_d;
  logic             start, one_col, last;
  logic [COL_W-1:0] len_mask;
  logic [COL_W-1:0] low_bits;

  assign start   = rd_start || wr_start;
  assign one_col = !rd_start && mode.single_wr;

  always_comb begin
    case (mode.blen)
      BL_2:    len_mask = COL_W'(1);
      BL_4:    len_mask = COL_W'(3);
      BL_8:    len_mask = COL_W'(7);
      BL_FULL: len_mask = '1;
      default: len_mask = '0;
    endcase
  end

  assign last = !full_q && (cnt_q == mask_q);

  always_comb begin
    act_d  = act_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    mask_d = mask_q;
    full_d = full_q;
    ilv_d  = ilv_q;
    rd_d   = rd_q;
    if (start) begin
      act_d  = 1'b1;
      base_d = start_col;
      cnt_d  = '0;
      mask_d = one_col ? '0 : len_mask;
      full_d = !one_col && (mode.blen == BL_FULL);
      ilv_d  = mode.interleave;
      rd_d   = rd_start;
    end else if (burst_stop) begin
      act_d = 1'b0;
    end else if (act_q) begin
      if (last) act_d = 1'b0;
      else      cnt_d = cnt_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      mask_q <= '0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      act_q  <= act_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
      mask_q <= mask_d;
      full_q <= full_d;
      ilv_q  <= ilv_d;
      rd_q   <= rd_d;
    end
  end

  assign low_bits    = ilv_q ? (base_q ^ cnt_q) : (base_q + cnt_q);
  assign col_addr    = (base_q & ~mask_q) | (low_bits & mask_q);
  assign col_valid   = act_q;
  assign col_is_read = rd_q;

endmodule

// File: rtl/sbs_rd_pipe.sv
module sbs_rd_pipe #(
  parameter int CL_MAX = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cas3,
  input  logic rd_col,
  output logic rd_valid,
  output logic pending
);

  localparam int IDX_W = (CL_MAX > 1) ? $clog2(CL_MAX) : 1;

  logic [CL_MAX-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]  tap;
  int                lat;

  assign sh_d = {sh_q[CL_MAX-2:0], rd_col};
  assign tap  = cas3 ? IDX_W'(2) : IDX_W'(1);
  assign lat  = cas3 ? 3 : 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  always_comb begin
    pending = 1'b0;
    for (int i = 0; i < CL_MAX; i++) begin
      if (i < lat) pending = pending | sh_q[i];
    end
  end

  assign rd_valid = sh_q[tap];

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sbs_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int CL_MAX = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_set,
  input  logic [13:0]      mode_word,
  input  logic             rd_start,
  input  logic             wr_start,
  input  logic [COL_W-1:0] start_col,
  input  logic             burst_stop,
  output logic [COL_W-1:0] col_addr,
  output logic             col_valid,
  output logic             rd_valid,
  output logic             mode_illegal,
  output logic             busy
);

  mode_t mode;
  logic  col_is_read;
  logic  rd_pending;

  sbs_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_set  (mode_set),
    .mode_word (mode_word),
    .mode      (mode),
    .illegal   (mode_illegal)
  );

  sbs_col_gen #(.COL_W(COL_W)) u_cols (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .rd_start    (rd_start),
    .wr_start    (wr_start),
    .start_col   (start_col),
    .burst_stop  (burst_stop),
    .col_addr    (col_addr),
    .col_valid   (col_valid),
    .col_is_read (col_is_read)
  );

  sbs_rd_pipe #(.CL_MAX(CL_MAX)) u_rdp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cas3     (mode.cas3),
    .rd_col   (col_valid && col_is_read),
    .rd_valid (rd_valid),
    .pending  (rd_pending)
  );

  assign busy = col_valid || rd_pending;

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_set,
  input logic [13:0]      mode_word,
  input logic             rd_start,
  input logic             wr_start,
  input logic [COL_W-1:0] start_col,
  input logic             burst_stop,
  input logic [COL_W-1:0] col_addr,
  input logic             col_valid,
  input logic             rd_valid,
  input logic             mode_illegal,
  input logic             busy
);

  // R2: a start issues its own column next cycle
  a_r2_start_issues: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start || wr_start) |=> (col_valid && col_addr == $past(start_col)));

  // R8: a terminate strobe without a start ends the burst
  a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_stop && !rd_start && !wr_start) |=> !col_valid);

  // R10: a set test bit is always rejected
  a_r10_test_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_set && mode_word[7]) |=> mode_illegal);

  // R1: the flag only moves on a mode set
  a_r1_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_set |=> $stable(mode_illegal));

  // R12: issuing columns or returning read data implies busy
  a_r12_busy_col: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> busy);
  a_r12_busy_rdv: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

endmodule

bind sdram_burst_seq sbs_checker #(.COL_W(COL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_set     (mode_set),
  .mode_word    (mode_word),
  .rd_start     (rd_start),
  .wr_start     (wr_start),
  .start_col    (start_col),
  .burst_stop   (burst_stop),
  .col_addr     (col_addr),
  .col_valid    (col_valid),
  .rd_valid     (rd_valid),
  .mode_illegal (mode_illegal),
  .busy         (busy)
);

// File: tb/sdram_burst_seq_tb.sv
module sdram_burst_seq_tb;

  logic        clk;
  logic        rst_n;
  logic        mode_set;
  logic [13:0] mode_word;
  logic        rd_start, wr_start, burst_stop;
  logic [8:0]  start_col;
  logic [8:0]  col_addr;
  logic        col_valid, rd_valid, mode_illegal, busy;

  int    n_vec;
  int    n_bad;
  int    n_cyc;
  string req;

  // reference model state
  int  m_bl;      // 1,2,4,8 or 0 for full page
  int  m_cl;
  bit  m_ilv, m_single, m_ill;
  bit  e_act, e_rd, e_full;
  int  e_col;
  int  eq[$];
  bit  hist [1:3];

  sdram_burst_seq u_dut (
    .clk(clk), .rst_n(rst_n), .mode_set(mode_set), .mode_word(mode_word),
    .rd_start(rd_start), .wr_start(wr_start), .start_col(start_col),
    .burst_stop(burst_stop), .col_addr(col_addr), .col_valid(col_valid),
    .rd_valid(rd_valid), .mode_illegal(mode_illegal), .busy(busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [13:0] mw(logic [5:0] op, bit tb, logic [2:0] cl,
                                     bit bt, logic [2:0] bl);
    return {op, tb, cl, bt, bl};
  endfunction

  task automatic model_mode(logic [13:0] w);
    int  len;
    bit  ok;
    ok  = 1;
    len = 0;
    if (w[13:8] != 6'd0 && w[13:8] != 6'd2) ok = 0;
    if (w[7]) ok = 0;
    if (w[6:4] != 3'd2 && w[6:4] != 3'd3) ok = 0;
    if (w[2:0] <= 3'd3) len = 1 << w[2:0];
    else if (w[2:0] == 3'd7 && !w[3]) len = 0;
    else ok = 0;
    m_ill = !ok;
    if (ok) begin
      m_bl     = len;
      m_cl     = (w[6:4] == 3'd3) ? 3 : 2;
      m_ilv    = w[3];
      m_single = (w[13:8] == 6'd2);
    end
  endtask

  task automatic model_step();
    int len, blk, off;
    hist[3] = hist[2];
    hist[2] = hist[1];
    hist[1] = e_act && e_rd;
    if (rd_start || wr_start) begin
      e_rd = rd_start;
      len  = (!rd_start && m_single) ? 1 : m_bl;
      eq.delete();
      e_full = (len == 0);
      if (e_full) begin
        e_col = start_col;
      end else begin
        blk = (start_col / len) * len;
        off = start_col % len;
        for (int n = 0; n < len; n++)
          eq.push_back(m_ilv ? blk + (off ^ n) : blk + ((off + n) % len));
        e_col = eq.pop_front();
      end
      e_act = 1;
    end else if (burst_stop) begin
      e_act = 0;
    end else if (e_act) begin
      if (e_full) e_col = (e_col + 1) % 512;
      else if (eq.size() > 0) e_col = eq.pop_front();
      else e_act = 0;
    end
    if (mode_set) model_mode(mode_word);
  endtask

  task automatic cmp1(string sig, int act, int exp);
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, sig, act, exp, n_cyc);
    end
  endtask

  task automatic compare();
    bit eb;
    n_vec++;
    eb = e_act || hist[1] || hist[2] || (m_cl == 3 && hist[3]);
    cmp1("col_valid", int'(col_valid), int'(e_act));
    if (e_act) cmp1("col_addr", int'(col_addr), e_col);
    cmp1("rd_valid", int'(rd_valid), int'(hist[m_cl]));
    cmp1("busy", int'(busy), int'(eb));
    cmp1("mode_illegal", int'(mode_illegal), int'(m_ill));
  endtask

  task automatic cyc();
    @(negedge clk);
    n_cyc++;
    model_step();
    compare();
  endtask

  task automatic idle(int n);
    repeat (n) cyc();
  endtask

  task automatic set_mode(logic [13:0] w);
    mode_set  = 1;
    mode_word = w;
    cyc();
    mode_set  = 0;
    cyc();
  endtask

  task automatic go(bit rd, bit wr, int col, int wait_n);
    rd_start  = rd;
    wr_start  = wr;
    start_col = 9'(col);
    cyc();
    rd_start = 0;
    wr_start = 0;
    idle(wait_n);
  endtask

  // watchdog
  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0; n_bad = 0; n_cyc = 0;
    mode_set = 0; mode_word = '0; rd_start = 0; wr_start = 0;
    burst_stop = 0; start_col = '0;
    m_bl = 1; m_cl = 2; m_ilv = 0; m_single = 0; m_ill = 0;
    e_act = 0; e_rd = 0; e_full = 0; e_col = 0;
    for (int i = 1; i <= 3; i++) hist[i] = 0;
    rst_n = 0;

    // R11: outputs during and straight after reset, default mode length 1 latency 2
    req = "R11";
    repeat (3) @(negedge clk);
    n_vec++;
    cmp1("col_valid", int'(col_valid), 0);
    cmp1("rd_valid", int'(rd_valid), 0);
    cmp1("busy", int'(busy), 0);
    cmp1("mode_illegal", int'(mode_illegal), 0);
    rst_n = 1;
    idle(2);
    go(1, 0, 37, 5);
    go(0, 1, 100, 5);

    // R3 / R4 / R5 / R7 / R9: every legal length, order, write policy and latency
    for (int bl = 0; bl < 4; bl++)
      for (int bt = 0; bt < 2; bt++)
        for (int sg = 0; sg < 2; sg++) begin
          req = sg ? "R7" : (bt ? "R5" : (bl == 0 ? "R3" : "R4"));
          set_mode(mw(sg ? 6'd2 : 6'd0, 0, ((bl + bt) % 2) ? 3'd3 : 3'd2,
                      bt[0], 3'(bl)));
          go(1, 0, 13, 11);
          go(0, 1, 250, 10);
          req = "R9";
          go(1, 0, 7 + bl, 12);
        end

    // R12: back-to-back reads keep busy high through trailing data
    req = "R12";
    set_mode(mw(6'd0, 0, 3'd3, 0, 3'd2));
    go(1, 0, 2, 3);
    go(1, 0, 9, 8);

    // R2: read and write strobes together choose the read
    req = "R2";
    set_mode(mw(6'd2, 0, 3'd2, 1, 3'd3));
    go(1, 1, 77, 12);

    // R6: full page read wraps past 511
    req = "R6";
    set_mode(mw(6'd0, 0, 3'd2, 0, 3'd7));
    go(1, 0, 505, 20);
    burst_stop = 1; cyc(); burst_stop = 0;
    idle(5);

    // R8: stop and preempt
    req = "R8";
    go(0, 1, 510, 5);
    go(1, 0, 3, 4);
    burst_stop = 1; cyc(); burst_stop = 0;
    idle(4);
    burst_stop = 1; cyc(); burst_stop = 0;
    idle(2);
    set_mode(mw(6'd0, 0, 3'd3, 1, 3'd3));
    go(1, 0, 44, 2);
    burst_stop = 1; cyc(); burst_stop = 0;
    idle(5);
    go(0, 1, 60, 3);
    go(1, 0, 61, 12);

    // R7: single write with full page still writes one column
    req = "R7";
    set_mode(mw(6'd2, 0, 3'd2, 0, 3'd7));
    go(0, 1, 300, 4);
    go(1, 0, 300, 6);
    burst_stop = 1; cyc(); burst_stop = 0;
    idle(4);

    // R10: reserved codes rejected, stored mode kept (checked by a following read)
    req = "R10";
    set_mode(mw(6'd0, 0, 3'd3, 1, 3'd2));
    go(1, 0, 21, 9);
    begin
      logic [13:0] bad [15];
      bad[0]  = mw(6'd0, 1, 3'd2, 0, 3'd1);
      bad[1]  = mw(6'd0, 0, 3'd2, 0, 3'd4);
      bad[2]  = mw(6'd0, 0, 3'd2, 0, 3'd5);
      bad[3]  = mw(6'd0, 0, 3'd2, 0, 3'd6);
      bad[4]  = mw(6'd0, 0, 3'd2, 1, 3'd7);
      bad[5]  = mw(6'd0, 0, 3'd0, 0, 3'd3);
      bad[6]  = mw(6'd0, 0, 3'd1, 0, 3'd3);
      bad[7]  = mw(6'd0, 0, 3'd4, 0, 3'd3);
      bad[8]  = mw(6'd0, 0, 3'd5, 0, 3'd3);
      bad[9]  = mw(6'd0, 0, 3'd6, 0, 3'd3);
      bad[10] = mw(6'd0, 0, 3'd7, 0, 3'd3);
      bad[11] = mw(6'd1, 0, 3'd2, 0, 3'd3);
      bad[12] = mw(6'd3, 0, 3'd2, 0, 3'd3);
      bad[13] = mw(6'd32, 0, 3'd2, 0, 3'd3);
      bad[14] = mw(6'd4, 0, 3'd2, 0, 3'd3);
      for (int k = 0; k < 15; k++) begin
        set_mode(bad[k]);
        go(1, 0, 21 + k, 9);
        go(0, 1, 40, 6);
      end
    end

    // R1: a legal word clears the flag and takes effect
    req = "R1";
    set_mode(mw(6'd0, 0, 3'd2, 0, 3'd3));
    go(1, 0, 6, 12);
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule